// File: doc/BRIEF.md
# PTP System Time Control Unit

This block keeps a precision-time-protocol system clock made of a seconds word and a subseconds word. The subseconds word rolls over at 2^31, and each rollover carries into the seconds word. The clock rate is trimmed by a fractional accumulator. On every cycle the active addend is added into a 32-bit accumulator. Each carry out of the accumulator advances the subseconds word by a programmable increment.

Software drives the unit through a write port of eight word registers. The control word holds four command flags. One loads a new addend into the time engine. One overwrites the time. One adds a signed offset to the time or subtracts it. One arms a target-time comparison. Each command may be set only while its flag reads zero, and the hardware clears the flag when the action is done. The init, offset and addend commands take effect one clock after the write. An armed target fires once the time passes the target. It then raises a level interrupt that stays high until software acknowledges it.

Top module: `ptp_time_ctrl`

## Requirements
- R1: After reset, the control readback is zero, both time words are zero and the interrupt is low.
- R2: Only control bits 2, 3, 4 and 5 can ever read one. Writes to every other control bit are ignored, and writing zero to a command bit leaves it unchanged.
- R3: A write to address 0 with bit 2 set starts the init command. Bit 2 reads one for exactly one cycle. On the next clock the seconds word becomes the value at address 3 and the subseconds word becomes bits 30:0 of address 4.
- R4: A write to address 0 with bit 3 set starts the offset command. When bit 31 of address 4 is zero, the next clock adds address 3 to the seconds word and bits 30:0 of address 4 to the subseconds word. A subseconds carry past 2^31 adds one more second.
- R5: When bit 31 of address 4 is one, the offset command subtracts both values instead. A subseconds borrow takes one more second away.
- R6: A write that sets bit 3 is ignored while bit 2 or bit 3 already reads one.
- R7: When one write starts both the init and the offset command, the time is loaded and the offset is discarded. Both bits clear on the next clock.
- R8: A value written to address 2 changes nothing until a write to address 0 with bit 5 starts the addend command. After that command, the subseconds word advances by the increment at address 1 (bits 7:0) on every carry out of the accumulator.
- R9: A subseconds rollover caused by an increment step adds one to the seconds word.
- R10: Bit 4 arms the target, which is held at addresses 5 (seconds) and 6 (subseconds, bits 30:0). The target fires only when the time is strictly greater than the target, comparing seconds first. When it fires, the interrupt rises one clock later and bit 4 clears in the same cycle. A time equal to the target does not fire.
- R11: The interrupt stays high until a write to address 7 with bit 0 set. The next clock lowers it. A write to address 7 with bit 0 clear leaves it high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register word address |
| wr_data | input | 32 | Register write data |
| ctrl_rd | output | 32 | Control word readback |
| sys_sec | output | 32 | System time, seconds |
| sys_subsec | output | 31 | System time, subseconds |
| irq | output | 1 | Target-time interrupt level |

## Verification
The bench goes after the handshake guard by writing back-to-back commands. In one case it sets the offset command during the single busy cycle of an init. In another it repeats the offset command. A design that does not check the flags would apply the offset a second time and leave the seconds word wrong. The bench also drives offsets that cross the subseconds boundary in both directions, and a tick step that wraps at 2^31. A design with a wrong carry or borrow path would leave the seconds word off by one. The target test first holds the time exactly equal to the target and then moves it one count past. A greater-or-equal comparator would fire too early, and a flag that does not clear itself would still read as armed. The bench also confirms that the addend register does nothing before its command, and that writing zero to the acknowledge bit does not drop the interrupt.

// File: rtl/ptp_time_pkg.sv
package ptp_time_pkg;
  localparam int ADDR_W = 3;
  typedef logic [ADDR_W-1:0] reg_addr_t;

  // word addresses on the write port
  localparam reg_addr_t A_CTRL    = 3'd0;
  localparam reg_addr_t A_INC     = 3'd1;
  localparam reg_addr_t A_ADDEND  = 3'd2;
  localparam reg_addr_t A_UPD_SEC = 3'd3;
  localparam reg_addr_t A_UPD_SUB = 3'd4;
  localparam reg_addr_t A_TGT_SEC = 3'd5;
  localparam reg_addr_t A_TGT_SUB = 3'd6;
  localparam reg_addr_t A_STATUS  = 3'd7;

  // command flag positions inside the control word
  localparam int B_INIT   = 2;
  localparam int B_UPD    = 3;
  localparam int B_ARM    = 4;
  localparam int B_ADDEND = 5;
endpackage

// File: rtl/ptp_ctrl_regs.sv
module ptp_ctrl_regs
  import ptp_time_pkg::*;
#(
  parameter int DW    = 32,
  parameter int INC_W = 8,
  localparam int SUB_W = DW - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  reg_addr_t        wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic             fire,
  output logic [DW-1:0]    ctrl_rd,
  output logic             init_q,
  output logic             upd_q,
  output logic             arm_q,
  output logic             addc_q,
  output logic             irq_ack,
  output logic [INC_W-1:0] inc_q,
  output logic [DW-1:0]    addend_q,
  output logic [DW-1:0]    upd_sec_q,
  output logic [DW-1:0]    upd_sub_q,
  output logic [DW-1:0]    tgt_sec_q,
  output logic [SUB_W-1:0] tgt_sub_q
);
  logic wr_ctrl;
  logic init_n, upd_n, arm_n, addc_n;

  assign wr_ctrl = wr_en && (wr_addr == A_CTRL);
  assign irq_ack = wr_en && (wr_addr == A_STATUS) && wr_data[0];

  // set only while clear; init/offset/addend retire after one cycle
  always_comb begin
    init_n = wr_ctrl && wr_data[B_INIT] && !init_q;
    upd_n  = wr_ctrl && wr_data[B_UPD] && !upd_q && !init_q;
    addc_n = wr_ctrl && wr_data[B_ADDEND] && !addc_q;
    if (fire) arm_n = 1'b0;
    else      arm_n = arm_q || (wr_ctrl && wr_data[B_ARM]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      init_q <= 1'b0;
      upd_q  <= 1'b0;
      arm_q  <= 1'b0;
      addc_q <= 1'b0;
    end else begin
      init_q <= init_n;
      upd_q  <= upd_n;
      arm_q  <= arm_n;
      addc_q <= addc_n;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      inc_q     <= '0;
      addend_q  <= '0;
      upd_sec_q <= '0;
      upd_sub_q <= '0;
      tgt_sec_q <= '0;
      tgt_sub_q <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_INC:     inc_q     <= wr_data[INC_W-1:0];
        A_ADDEND:  addend_q  <= wr_data;
        A_UPD_SEC: upd_sec_q <= wr_data;
        A_UPD_SUB: upd_sub_q <= wr_data;
        A_TGT_SEC: tgt_sec_q <= wr_data;
        A_TGT_SUB: tgt_sub_q <= wr_data[SUB_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    ctrl_rd           = '0;
    ctrl_rd[B_INIT]   = init_q;
    ctrl_rd[B_UPD]    = upd_q;
    ctrl_rd[B_ARM]    = arm_q;
    ctrl_rd[B_ADDEND] = addc_q;
  end

  // R3
  init_clear_chk: assert property (@(posedge clk) disable iff (rst)
    init_q |=> !init_q);

  // R6
  upd_guard_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(upd_q) |-> !$past(init_q));

  // R10
  arm_clear_chk: assert property (@(posedge clk) disable iff (rst)
    fire |=> !arm_q);
endmodule

// File: rtl/ptp_time_engine.sv
module ptp_time_engine #(
  parameter int DW    = 32,
  parameter int INC_W = 8,
  localparam int SUB_W = DW - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_init,
  input  logic             cmd_upd,
  input  logic             cmd_addend,
  input  logic [DW-1:0]    addend_q,
  input  logic [INC_W-1:0] inc_q,
  input  logic [DW-1:0]    upd_sec,
  input  logic [DW-1:0]    upd_sub,
  output logic [DW-1:0]    sec_q,
  output logic [SUB_W-1:0] sub_q
);
  logic [DW-1:0]    acc_q, active_q;
  logic [DW:0]      acc_sum;
  logic             tick;
  logic [SUB_W:0]   step_sum, add_sum, sub_diff;
  logic [SUB_W-1:0] mag;
  logic             neg;
  logic [DW-1:0]    sec_add, sec_sub;

  assign acc_sum  = {1'b0, acc_q} + {1'b0, active_q};
  assign tick     = acc_sum[DW];
  assign step_sum = {1'b0, sub_q} + {{(DW-INC_W){1'b0}}, inc_q};

  assign neg      = upd_sub[SUB_W];
  assign mag      = upd_sub[SUB_W-1:0];
  assign add_sum  = {1'b0, sub_q} + {1'b0, mag};
  assign sub_diff = {1'b0, sub_q} - {1'b0, mag};
  assign sec_add  = sec_q + upd_sec + {{(DW-1){1'b0}}, add_sum[SUB_W]};
  assign sec_sub  = sec_q - upd_sec - {{(DW-1){1'b0}}, sub_diff[SUB_W]};

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q    <= '0;
      active_q <= '0;
      sec_q    <= '0;
      sub_q    <= '0;
    end else begin
      acc_q <= acc_sum[DW-1:0];
      if (cmd_addend) active_q <= addend_q;
      if (cmd_init) begin
        sec_q <= upd_sec;
        sub_q <= mag;
      end else if (cmd_upd) begin
        sec_q <= neg ? sec_sub : sec_add;
        sub_q <= neg ? sub_diff[SUB_W-1:0] : add_sum[SUB_W-1:0];
      end else if (tick) begin
        sec_q <= sec_q + {{(DW-1){1'b0}}, step_sum[SUB_W]};
        sub_q <= step_sum[SUB_W-1:0];
      end
    end
  end

  // R3
  init_load_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_init |=> (sec_q == $past(upd_sec)) && (sub_q == $past(upd_sub[SUB_W-1:0])));
endmodule

// File: rtl/ptp_target_cmp.sv
module ptp_target_cmp #(
  parameter int DW = 32,
  localparam int SUB_W = DW - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm,
  input  logic             ack,
  input  logic [DW-1:0]    sec,
  input  logic [SUB_W-1:0] sub,
  input  logic [DW-1:0]    tgt_sec,
  input  logic [SUB_W-1:0] tgt_sub,
  output logic             fire,
  output logic             irq_q
);
  logic past_tgt;

  assign past_tgt = {sec, sub} > {tgt_sec, tgt_sub};
  assign fire     = arm && past_tgt;

  always_ff @(posedge clk) begin
    if (rst)       irq_q <= 1'b0;
    else if (fire) irq_q <= 1'b1;
    else if (ack)  irq_q <= 1'b0;
  end

  // R10
  irq_set_chk: assert property (@(posedge clk) disable iff (rst)
    (arm && past_tgt) |=> irq_q);

  // R11
  irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_q && !ack) |=> irq_q);
endmodule

// File: rtl/ptp_time_ctrl.sv
module ptp_time_ctrl
  import ptp_time_pkg::*;
#(
  parameter int DW    = 32,
  parameter int INC_W = 8,
  localparam int SUB_W = DW - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  output logic [DW-1:0]     ctrl_rd,
  output logic [DW-1:0]     sys_sec,
  output logic [SUB_W-1:0]  sys_subsec,
  output logic              irq
);
  logic             init_q, upd_q, arm_q, addc_q, irq_ack, fire;
  logic [INC_W-1:0] inc_q;
  logic [DW-1:0]    addend_q, upd_sec_q, upd_sub_q, tgt_sec_q;
  logic [SUB_W-1:0] tgt_sub_q;

  ptp_ctrl_regs #(.DW(DW), .INC_W(INC_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .fire(fire), .ctrl_rd(ctrl_rd), .init_q(init_q), .upd_q(upd_q),
    .arm_q(arm_q), .addc_q(addc_q), .irq_ack(irq_ack), .inc_q(inc_q),
    .addend_q(addend_q), .upd_sec_q(upd_sec_q), .upd_sub_q(upd_sub_q),
    .tgt_sec_q(tgt_sec_q), .tgt_sub_q(tgt_sub_q)
  );

  ptp_time_engine #(.DW(DW), .INC_W(INC_W)) u_engine (
    .clk(clk), .rst(rst), .cmd_init(init_q), .cmd_upd(upd_q),
    .cmd_addend(addc_q), .addend_q(addend_q), .inc_q(inc_q),
    .upd_sec(upd_sec_q), .upd_sub(upd_sub_q), .sec_q(sys_sec), .sub_q(sys_subsec)
  );

  ptp_target_cmp #(.DW(DW)) u_cmp (
    .clk(clk), .rst(rst), .arm(arm_q), .ack(irq_ack), .sec(sys_sec),
    .sub(sys_subsec), .tgt_sec(tgt_sec_q), .tgt_sub(tgt_sub_q),
    .fire(fire), .irq_q(irq)
  );
endmodule

// File: tb/ptp_time_ctrl_tb.sv
module ptp_time_ctrl_tb;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] ctrl_rd, sys_sec;
  logic [30:0] sys_subsec;
  logic        irq;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  ptp_time_ctrl u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ctrl_rd(ctrl_rd), .sys_sec(sys_sec), .sys_subsec(sys_subsec), .irq(irq)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // called at a falling edge; the write lands on the next rising edge
  task automatic wr(logic [2:0] a, logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1 ctrl", ctrl_rd, 0);
    check("R1 sec", sys_sec, 0);
    check("R1 subsec", sys_subsec, 0);
    check("R1 irq", irq, 0);
  endtask

  task automatic t_init;
    wr(3, 100); wr(4, 32'h1234); wr(0, 32'h4);
    check("R3 busy", ctrl_rd, 32'h4);
    tick(1);
    check("R3 done", ctrl_rd, 0);
    check("R3 sec", sys_sec, 100);
    check("R3 subsec", sys_subsec, 31'h1234);
  endtask

  task automatic t_reserved;
    wr(0, 32'hFFFF_FFC3);
    check("R2 ctrl", ctrl_rd, 0);
    tick(1);
    check("R2 sec", sys_sec, 100);
    check("R2 subsec", sys_subsec, 31'h1234);
  endtask

  task automatic t_add;
    wr(3, 5); wr(4, 32'h10); wr(0, 32'h8);
    check("R4 busy", ctrl_rd, 32'h8);
    tick(1);
    check("R4 sec", sys_sec, 105);
    check("R4 subsec", sys_subsec, 31'h1244);
    wr(3, 7); wr(4, 32'h7FFF_FFF0); wr(0, 32'h4); tick(1);
    wr(3, 0); wr(4, 32'h20); wr(0, 32'h8); tick(1);
    check("R4 carry sec", sys_sec, 8);
    check("R4 carry subsec", sys_subsec, 31'h10);
  endtask

  task automatic t_sub;
    wr(3, 1); wr(4, 32'h8000_0020); wr(0, 32'h8); tick(1);
    check("R5 borrow sec", sys_sec, 6);
    check("R5 borrow subsec", sys_subsec, 31'h7FFF_FFF0);
  endtask

  task automatic t_guard;
    wr(3, 50); wr(4, 0); wr(0, 32'h4); wr(0, 32'h8);
    check("R6 ctrl after init-busy write", ctrl_rd, 0);
    check("R6 sec", sys_sec, 50);
    tick(1);
    check("R6 no late offset", sys_sec, 50);
    wr(3, 2); wr(0, 32'h8); wr(0, 32'h8);
    check("R6 ctrl after repeat", ctrl_rd, 0);
    tick(1);
    check("R6 single offset", sys_sec, 52);
  endtask

  task automatic t_addend;
    wr(1, 3);
    wr(3, 9); wr(4, 32'h7FFF_FFFE); wr(0, 32'h4); tick(1);
    wr(2, 32'h8000_0000); tick(4);
    check("R8 no effect before command", sys_subsec, 31'h7FFF_FFFE);
    wr(0, 32'h20);
    check("R8 busy", ctrl_rd, 32'h20);
    tick(1);
    check("R8 done", ctrl_rd, 0);
    tick(2);
    check("R9 wrap subsec", sys_subsec, 31'h1);
    check("R9 wrap sec", sys_sec, 10);
    begin
      logic [30:0] s0;
      s0 = sys_subsec;
      tick(20);
      check("R8 rate", 31'(sys_subsec - s0), 31'd30);
    end
    wr(2, 0); wr(0, 32'h20); tick(2);
  endtask

  task automatic t_target;
    wr(3, 20); wr(4, 0); wr(0, 32'h4); tick(1);
    wr(5, 20); wr(6, 0); wr(0, 32'h10);
    check("R10 armed", ctrl_rd, 32'h10);
    tick(3);
    check("R10 equal no fire", irq, 0);
    check("R10 still armed", ctrl_rd, 32'h10);
    wr(3, 0); wr(4, 1); wr(0, 32'h8);
    tick(1);
    check("R10 not yet", irq, 0);
    tick(1);
    check("R10 fired", irq, 1);
    check("R10 arm cleared", ctrl_rd, 0);
    tick(3);
    check("R11 hold", irq, 1);
    wr(7, 0);
    check("R11 zero ack ignored", irq, 1);
    wr(7, 1);
    check("R11 ack", irq, 0);
    tick(2);
    check("R11 no refire", irq, 0);
  endtask

  task automatic t_both;
    wr(3, 7); wr(4, 3); wr(0, 32'hC);
    check("R7 busy", ctrl_rd, 32'hC);
    tick(1);
    check("R7 ctrl", ctrl_rd, 0);
    check("R7 sec", sys_sec, 7);
    check("R7 subsec", sys_subsec, 31'h3);
  endtask

  initial begin
    tick(3);
    rst = 1'b0;
    t_reset();
    t_init();
    t_reserved();
    t_add();
    t_sub();
    t_guard();
    t_addend();
    t_target();
    t_both();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule